// File: doc/BRIEF.md
# Memory Port Bandwidth Monitor

This block sits next to a memory controller arbiter and counts traffic. Each clock it samples a request strobe and a grant strobe. The grant carries the ID of the port that won arbitration. IDs below 32 are major ports. IDs of 32 and above are device sub-ports, numbered by subtracting 32 from the ID. The block keeps a count of all requests and of all grants. It also keeps one grant count per filter channel. Each of the four channels has a primary port bitmask and a secondary sub-port bitmask.

Software programs the block through a small word-addressed register bus. Register index `i` sits at byte address `4*i`. Counting can run freely. It can also be bounded by a window of a programmed number of clock cycles. When the window closes, the counters freeze, a done flag is set and an interrupt is raised. The results then stay in place until software reads them and clears the flag.

Top module: `bwmon_top`

## Requirements
- R1: After synchronous reset, every register reads as zero, `bus_rdata` is zero and `irq` is low.
- R2: A write at byte address `4*i` (i = `bus_addr[5:2]`; `bus_addr[1:0]` ignored) updates register i, and a read returns it on `bus_rdata` one clock after `bus_rd`. Register indices are as follows:
  - 0 is control.
  - 1+2c and 2+2c are the primary and secondary masks of channel c.
  - 9 is the request count.
  - 10 is the grant count.
  - 11+c is the grant count of channel c.
  - 15 is the window length.
- R3: While counting is active, the request count rises by one for each cycle with `req_vld` high, and the grant count rises by one for each cycle with `gnt_vld` high. Counting is active when control bit 31 is set, control bit 30 is clear and the window has not expired.
- R4: A grant to a port p below 32 increments channel c when control bit c is set and bit p of that channel's primary mask is set. If control bit c is clear, channel c never counts.
- R5: A grant to an ID p of 32 or more increments channel c only when primary bit 23 is set and secondary bit (p-32) is set. If primary bit 23 is clear, such a grant is not counted.
- R6: One grant increments every channel whose filter matches it in the same cycle.
- R7: A control write with bit 31 and bit 20 both set starts a window of N cycles, where N is the value in register 15. Strobes on exactly the N clocks after the write are counted. Control bit 30 is then set, and all counters hold their values until bit 30 is cleared.
- R8: `irq` is high exactly when control bit 30 and control bit 31 are both set.
- R9: Writing control with bit 30 set clears bit 30. Writing control with bit 30 clear leaves bit 30 unchanged.
- R10: Any write to a counter register (indices 9 to 14) clears that counter, whatever the write data.
- R11: Counters saturate at all ones instead of wrapping.
- R12: With control bit 20 clear, counting runs without a window and bit 30 is never set.
- R13: With control bit 31 clear, no counter changes on any strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W (6) | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| req_vld | input | 1 | Arbiter request strobe |
| gnt_vld | input | 1 | Arbiter grant strobe |
| gnt_port | input | PORT_W (6) | Port or device sub-port ID of the grant |
| irq | output | 1 | Window-done interrupt |

## Verification
Windowed counting is tested with a grant stream that runs three cycles longer than the window. A count equal to the window length shows that the window has the right length and ends on the right clock.

Free-running counting is tested with a mix of grants:
- A major port matched by two channels shows that one grant can count on several channels at once.
- A device sub-port is matched through the select bit and not matched without it.
- Another major port matches one channel only.
- A grant for a disabled channel shows that the per-channel enable works.

Strobes sent after the window closes and after the monitor is disabled show that the counters hold. A long run of requests with narrow counters shows that they saturate.

// File: rtl/bwmon_pkg.sv
package bwmon_pkg;
  localparam int REG_W       = 32;
  localparam int IDX_CTRL    = 0;
  localparam int IDX_MASK0   = 1;
  localparam int IDX_REQ     = 9;
  localparam int IDX_TMR     = 15;
  localparam int BIT_EN      = 31;
  localparam int BIT_DONE    = 30;
  localparam int BIT_TMODE   = 20;
  localparam int DEV_SEL_BIT = 23;
  localparam int MAJOR_PORTS = 32;
endpackage

// File: rtl/bwmon_chan_filter.sv
module bwmon_chan_filter
  import bwmon_pkg::*;
#(
  parameter int PORT_W = 6
) (
  input  logic [PORT_W-1:0] gnt_port,
  input  logic [REG_W-1:0]  prim_mask,
  input  logic [REG_W-1:0]  sec_mask,
  output logic              hit
);
  logic [PORT_W-1:0] sub_id;
  logic              is_major;

  assign is_major = gnt_port < PORT_W'(MAJOR_PORTS);
  assign sub_id   = gnt_port - PORT_W'(MAJOR_PORTS);

  always_comb begin
    if (is_major) begin
      hit = prim_mask[gnt_port[4:0]];
    end else begin
      // device traffic: select bit plus sub-port bit
      hit = prim_mask[DEV_SEL_BIT] && (sub_id < PORT_W'(MAJOR_PORTS))
            && sec_mask[sub_id[4:0]];
    end
  end
endmodule

// File: rtl/bwmon_sat_cnt.sv
module bwmon_sat_cnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (inc && (cnt != '1)) begin
      cnt <= cnt + 1'b1;
    end
  end

  a_r11_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (cnt == '1 && !clr) |=> cnt == '1);

  a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!inc && !clr) |=> $stable(cnt));
endmodule

// File: rtl/bwmon_window.sv
module bwmon_window #(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          tmode,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  input  logic          clr_done,
  output logic          run,
  output logic          done
);
  logic [TW-1:0] remain_q;
  logic          win_open;
  logic          expire;

  assign win_open = !tmode || (remain_q != '0);
  assign run      = en && !done && win_open;
  assign expire   = en && tmode && !done && !load && (remain_q <= TW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      remain_q <= '0;
      done     <= 1'b0;
    end else begin
      if (load) begin
        remain_q <= load_val;
      end else if (run && tmode) begin
        remain_q <= remain_q - 1'b1;
      end
      if (clr_done) begin
        done <= 1'b0;
      end else if (expire) begin
        done <= 1'b1;
      end
    end
  end

  a_r7_done_needs_window: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(en && tmode));

  a_r7_done_at_end: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(remain_q) <= TW'(1));

  a_r12_no_done_free: assert property (@(posedge clk) disable iff (rst)
    (!tmode && !done && !load) |=> !done);
endmodule

// File: rtl/bwmon_top.sv
module bwmon_top
  import bwmon_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 32,
  parameter int TMR_W  = 32,
  parameter int PORT_W = 6,
  parameter int N_CH   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              req_vld,
  input  logic              gnt_vld,
  input  logic [PORT_W-1:0] gnt_port,
  output logic              irq
);
  localparam int IDX_W = ADDR_W - 2;
  localparam int N_CNT = 2 + N_CH;

  logic [IDX_W-1:0]            idx;
  logic                        addr_unused;
  logic                        en_q, tmode_q;
  logic [N_CH-1:0]             chen_q;
  logic [N_CH-1:0][REG_W-1:0]  prim_q, sec_q;
  logic [TMR_W-1:0]            tmr_q;
  logic                        wr_ctrl, win_run, win_done;
  logic [N_CH-1:0]             ch_hit;
  logic [N_CNT-1:0]            cnt_inc, cnt_clr;
  logic [N_CNT-1:0][CNT_W-1:0] cnt_val;
  logic [REG_W-1:0]            rd_word;

  assign idx         = bus_addr[ADDR_W-1:2];
  assign addr_unused = ^bus_addr[1:0];
  assign wr_ctrl     = bus_wr && (int'(idx) == IDX_CTRL);

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      tmode_q <= 1'b0;
      chen_q  <= '0;
      prim_q  <= '0;
      sec_q   <= '0;
      tmr_q   <= '0;
    end else if (bus_wr) begin
      if (int'(idx) == IDX_CTRL) begin
        en_q    <= bus_wdata[BIT_EN];
        tmode_q <= bus_wdata[BIT_TMODE];
        chen_q  <= bus_wdata[N_CH-1:0];
      end
      if (int'(idx) == IDX_TMR) tmr_q <= bus_wdata[TMR_W-1:0];
      for (int c = 0; c < N_CH; c++) begin
        if (int'(idx) == IDX_MASK0 + 2*c)     prim_q[c] <= bus_wdata;
        if (int'(idx) == IDX_MASK0 + 2*c + 1) sec_q[c]  <= bus_wdata;
      end
    end
  end

  bwmon_window #(.TW(TMR_W)) u_window (
    .clk      (clk),
    .rst      (rst),
    .en       (en_q),
    .tmode    (tmode_q),
    .load     (wr_ctrl && bus_wdata[BIT_EN] && bus_wdata[BIT_TMODE]),
    .load_val (tmr_q),
    .clr_done (wr_ctrl && bus_wdata[BIT_DONE]),
    .run      (win_run),
    .done     (win_done)
  );

  assign cnt_inc[0] = win_run && req_vld;
  assign cnt_inc[1] = win_run && gnt_vld;

  for (genvar c = 0; c < N_CH; c++) begin : g_chan
    bwmon_chan_filter #(.PORT_W(PORT_W)) u_filt (
      .gnt_port  (gnt_port),
      .prim_mask (prim_q[c]),
      .sec_mask  (sec_q[c]),
      .hit       (ch_hit[c])
    );
    assign cnt_inc[2+c] = win_run && gnt_vld && chen_q[c] && ch_hit[c];

    a_r4_chan_off_hold: assert property (@(posedge clk) disable iff (rst)
      (!chen_q[c] && !bus_wr) |=> $stable(cnt_val[2+c]));
  end

  for (genvar k = 0; k < N_CNT; k++) begin : g_cnt
    assign cnt_clr[k] = bus_wr && (int'(idx) == IDX_REQ + k);
    bwmon_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk (clk),
      .rst (rst),
      .clr (cnt_clr[k]),
      .inc (cnt_inc[k]),
      .cnt (cnt_val[k])
    );
  end

  // read mux and registered read data
  always_comb begin
    rd_word = '0;
    if (int'(idx) == IDX_CTRL) begin
      rd_word[BIT_EN]     = en_q;
      rd_word[BIT_DONE]   = win_done;
      rd_word[BIT_TMODE]  = tmode_q;
      rd_word[N_CH-1:0]   = chen_q;
    end
    if (int'(idx) == IDX_TMR) rd_word[TMR_W-1:0] = tmr_q;
    for (int c = 0; c < N_CH; c++) begin
      if (int'(idx) == IDX_MASK0 + 2*c)     rd_word = prim_q[c];
      if (int'(idx) == IDX_MASK0 + 2*c + 1) rd_word = sec_q[c];
    end
    for (int k = 0; k < N_CNT; k++) begin
      if (int'(idx) == IDX_REQ + k) rd_word[CNT_W-1:0] = cnt_val[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= rd_word;
    end
  end

  assign irq = en_q && win_done;

  a_r7_frozen: assert property (@(posedge clk) disable iff (rst)
    (win_done && !bus_wr) |=> $stable(cnt_val[1]));

  a_r9_w1c: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && bus_wdata[BIT_DONE]) |=> !win_done);

  a_r13_off_hold: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !bus_wr) |=> $stable(cnt_val[0]));
endmodule

// File: tb/bwmon_top_bench.sv
module bwmon_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        req_vld = 1'b0, gnt_vld = 1'b0;
  logic [5:0]  gnt_port = '0;
  logic        irq;

  int n_run = 0;
  int n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always #5 clk = ~clk;

  bwmon_top #(.CNT_W(8)) u_bwmon_top (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .req_vld(req_vld), .gnt_vld(gnt_vld), .gnt_port(gnt_port), .irq(irq)
  );

  always @(posedge clk) rd_seen <= bus_rd;

  // monitor: pop expected read data and compare
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_run++;
      if (bus_rdata !== e) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", t, bus_rdata, e);
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = 6'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    bus_rd = 1'b1; bus_addr = 6'(a);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic ev(input logic r, input logic g, input int p, input int n);
    req_vld = r; gnt_vld = g; gnt_port = 6'(p);
    repeat (n) @(negedge clk);
    req_vld = 1'b0; gnt_vld = 1'b0;
  endtask

  task automatic chk(input string t, input logic [31:0] a, input logic [31:0] e);
    n_run++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", t, a, e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 rdata", bus_rdata, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    rd(0, 32'h0, "R1 ctrl");
    rd(9*4, 32'h0, "R1 req count");
    rd(15*4, 32'h0, "R1 timer");
    // R2 register access, low address bits ignored
    wr(1*4 + 3, 32'hA5A5_5A5A);
    rd(1*4, 32'hA5A5_5A5A, "R2 mask");
    wr(15*4, 32'h0000_1234);
    rd(15*4 + 2, 32'h0000_1234, "R2 timer");
    // R7 timed window of 5 cycles, grants for 8
    wr(1*4, 32'h1); wr(2*4, 32'hFFFF); wr(15*4, 5);
    wr(0, 32'h8010_0001);
    ev(0, 1, 0, 8);
    rd(10*4, 5, "R7 grant count window");
    rd(11*4, 5, "R7 ch0 count window");
    rd(0, 32'hC010_0001, "R7 done flag");
    chk("R8 irq high", {31'h0, irq}, 32'h1);
    // R9 writing without bit30 keeps flag; counts frozen
    wr(0, 32'h8010_0001);
    ev(1, 1, 0, 3);
    rd(10*4, 5, "R7 frozen after done");
    rd(0, 32'hC010_0001, "R9 flag kept");
    // R8 irq needs enable
    wr(0, 32'h0010_0001);
    chk("R8 irq low when disabled", {31'h0, irq}, 32'h0);
    rd(0, 32'h4010_0001, "R8 flag without enable");
    wr(0, 32'h4000_0000);
    rd(0, 32'h0, "R9 w1c clear");
    // R10 counter write clears
    wr(10*4, 32'hDEAD_BEEF);
    wr(11*4, 32'h1234_5678);
    rd(10*4, 0, "R10 grant cleared");
    rd(11*4, 0, "R10 ch0 cleared");
    // free-running mix, channel 0 disabled
    wr(1*4, 32'h8);        wr(2*4, 32'hFFFF);
    wr(3*4, 32'h28);       wr(4*4, 32'hFFFF);
    wr(5*4, 32'h0080_0008); wr(6*4, 32'h4);
    wr(7*4, 32'h0);        wr(8*4, 32'h8);
    wr(0, 32'h8000_000E);
    ev(1, 1, 3, 2);
    ev(0, 1, 5, 1);
    ev(1, 1, 34, 2);
    ev(0, 1, 35, 1);
    ev(0, 0, 0, 3);
    rd(9*4, 4, "R3 req count");
    rd(10*4, 6, "R3 grant count");
    rd(11*4, 0, "R4 ch0 disabled");
    rd(12*4, 3, "R6 ch1 shared grant");
    rd(13*4, 4, "R5 ch2 sub-port");
    rd(14*4, 0, "R5 ch3 no select");
    rd(0, 32'h8000_000E, "R12 no done free run");
    chk("R12 irq low", {31'h0, irq}, 32'h0);
    // R13 disabled monitor
    wr(0, 32'h0);
    ev(1, 1, 3, 4);
    rd(9*4, 4, "R13 req hold");
    rd(12*4, 3, "R13 ch1 hold");
    // R11 saturation with 8-bit counters
    wr(9*4, 0);
    wr(0, 32'h8000_0000);
    ev(1, 0, 0, 300);
    wr(0, 32'h0);
    rd(9*4, 255, "R11 saturate");
    rd(10*4, 6, "R11 grant untouched");
    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule